// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block lets an external host read and write a small bank of byte registers over a two-wire serial bus (SCL clock, SDA data). It runs entirely in the system clock domain. Both bus lines are oversampled through a synchronizer and a majority filter. SDA is driven through an open-drain enable: when the enable is high, the pad pulls the line low. The slave recognises START, repeated START and STOP conditions. It answers one fixed 7-bit device address. A write transaction first loads an 8-bit register pointer. Every data byte after that goes to the register the pointer selects, and the pointer then moves up by one.

The pointer is kept across a repeated START and across STOP. A host can therefore load the pointer in write direction, issue a repeated START in read direction, and stream out consecutive registers. Reads past the last implemented register return zero. Writes there are acknowledged but dropped. The pointer is eight bits wide and wraps from FFh to 00h.

The surrounding logic reads any register through a combinational parallel port. Every stored write also shows up as a one-cycle strobe carrying the register index and the data.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset, sda_oe is 0 and every register reads 00h on the parallel port.
- R2: Only the device address 0110011 (33h) in the upper seven bits of the first byte is acknowledged. The lowest bit of that byte is the direction: 0 means write, 1 means read. For any other address, SDA is never pulled, and later bytes are neither acknowledged nor stored until the next START or STOP.
- R3: In write direction, the byte after the address is loaded into the pointer. Each further byte is acknowledged and stored at the pointer, after which the pointer increments. Each stored byte raises wr_stb for exactly one clock, with wr_addr and wr_data valid in that cycle.
- R4: Data bytes written while the pointer is 16 or higher are acknowledged, change no register, and raise no wr_stb.
- R5: After the address in read direction, the slave sends the register at the pointer, MSB first. Each byte the host acknowledges is followed by the next register.
- R6: A read while the pointer is 16 or higher returns 00h.
- R7: The pointer wraps from FFh to 00h.
- R8: The pointer keeps its value across STOP and across repeated START. A read transaction with no pointer byte therefore continues where the previous transfer left off.
- R9: After the host answers a read byte with a not-acknowledge, the slave releases SDA and stays off the bus until the next START or STOP.
- R10: sda_oe changes only while SCL is low.
- R11: An SCL pulse lasting a single clock cycle is filtered out and does not disturb a transfer.
- R12: After a repeated START, an address in write direction is accepted. The byte that follows is taken as a new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| par_addr | input | clog2(NREGS) | Register index for the parallel read port |
| par_rdata | output | 8 | Contents of the register at par_addr |
| wr_stb | output | 1 | One-cycle pulse for each stored write |
| wr_addr | output | 8 | Register index of the stored write |
| wr_data | output | 8 | Data of the stored write |

## Verification
The address decoder is tried with all 128 seven-bit addresses in write direction. This separates the single matching code from every near miss; a mismatch is also followed by data bytes to confirm they are neither acknowledged nor stored. The data path is tried with a full 16-byte write sweep, a combined write-pointer/read burst that runs past the last register, a pointer load at FFh, and a repeated-START write. Between them these distinguish correct storage, incrementing, the zero fill above the bank, pointer wrap and pointer retention. A single-cycle SCL glitch injected into every bit of one byte shows whether the filter keeps spurious edges away from the bit counter.

// File: rtl/twi_pkg.sv
// Shared types for the two-wire register slave.
package twi_pkg;

    // Protocol states of the slave controller
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_PTR,
        ST_PTRACK,
        ST_WRBYTE,
        ST_WRACK,
        ST_RDBYTE,
        ST_RDACK,
        ST_SKIP
    } twi_state_e;

endpackage

// File: rtl/twi_line_filter.sv
// Brings one asynchronous bus line into the clock domain. A chain of
// SYNC_STAGES flops is followed by a TAPS-sample majority vote, so a
// pulse shorter than TAPS/2+1 samples never reaches the output.
// Assumes: SYNC_STAGES >= 2, TAPS odd and >= 3. The idle line is high.
module twi_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int TAPS        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(TAPS + 1);
    localparam int HALF  = TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [TAPS-1:0]        win_q;
    logic [CNT_W-1:0]       ones;
    logic                   line_q;

    // Count the high samples in the voting window
    always_comb begin
        ones = '0;
        for (int i = 0; i < TAPS; i++) begin
            ones = ones + CNT_W'(win_q[i]);
        end
    end

    // Synchronize, shift the window and register the majority decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            line_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            win_q  <= {win_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
            line_q <= (int'(ones) > HALF);
        end
    end

    assign line_o = line_q;
endmodule

// File: rtl/twi_bus_events.sv
// Turns the filtered SCL and SDA levels into single-cycle events:
// SCL rising, SCL falling, START (SDA falls while SCL high) and STOP
// (SDA rises while SCL high). Assumes both inputs are already clean.
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_prev;
    logic sda_prev;

    // Remember the previous levels of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    // Decode edges and bus conditions
    always_comb begin
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/twi_slave_fsm.sv
// Protocol controller of the register slave. It samples SDA on SCL rising
// edges and changes its SDA enable only on SCL falling edges. It matches
// DEV_ID, loads the 8-bit pointer, issues write requests and shifts out
// read data. The pointer increments after every data byte and is kept
// across STOP and repeated START. Assumes no clock stretching is needed.
module twi_slave_fsm
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ID = 7'h33,
    parameter int         AW     = 8,
    parameter int         DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          sda_lvl,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] ptr,
    output logic          sda_oe,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output twi_state_e    state
);
    localparam int BIT_W = $clog2(DW + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW);

    twi_state_e     state_q;
    logic [DW-1:0]  shift_q;
    logic [BIT_W-1:0] bit_q;
    logic [AW-1:0]  ptr_q;
    logic           oe_q;
    logic           dir_rd_q;
    logic           host_ack_q;
    logic           req_q;
    logic [AW-1:0]  req_addr_q;
    logic [DW-1:0]  req_data_q;

    // Sequence the protocol one bus event at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            shift_q    <= '0;
            bit_q      <= '0;
            ptr_q      <= '0;
            oe_q       <= 1'b0;
            dir_rd_q   <= 1'b0;
            host_ack_q <= 1'b0;
            req_q      <= 1'b0;
            req_addr_q <= '0;
            req_data_q <= '0;
        end else begin
            req_q <= 1'b0;
            if (stop_det) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else if (start_det) begin
                state_q <= ST_DEVADDR;
                oe_q    <= 1'b0;
                bit_q   <= '0;
            end else begin
                unique case (state_q)
                    ST_DEVADDR: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[DW-2:0], sda_lvl};
                            bit_q   <= bit_q + 1'b1;
                        end else if (scl_fall && bit_q == LAST_BIT) begin
                            bit_q <= '0;
                            if (shift_q[DW-1:1] == DEV_ID) begin
                                dir_rd_q <= shift_q[0];
                                oe_q     <= 1'b1;
                                state_q  <= ST_DEVACK;
                            end else begin
                                state_q  <= ST_SKIP;
                            end
                        end
                    end
                    ST_DEVACK: begin
                        if (scl_fall) begin
                            bit_q <= '0;
                            if (dir_rd_q) begin
                                shift_q <= rd_data;
                                oe_q    <= ~rd_data[DW-1];
                                state_q <= ST_RDBYTE;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[DW-2:0], sda_lvl};
                            bit_q   <= bit_q + 1'b1;
                        end else if (scl_fall && bit_q == LAST_BIT) begin
                            ptr_q   <= AW'(shift_q);
                            bit_q   <= '0;
                            oe_q    <= 1'b1;
                            state_q <= ST_PTRACK;
                        end
                    end
                    ST_PTRACK, ST_WRACK: begin
                        if (scl_fall) begin
                            oe_q    <= 1'b0;
                            state_q <= ST_WRBYTE;
                        end
                    end
                    ST_WRBYTE: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[DW-2:0], sda_lvl};
                            bit_q   <= bit_q + 1'b1;
                        end else if (scl_fall && bit_q == LAST_BIT) begin
                            req_q      <= 1'b1;
                            req_addr_q <= ptr_q;
                            req_data_q <= shift_q;
                            ptr_q      <= ptr_q + 1'b1;
                            bit_q      <= '0;
                            oe_q       <= 1'b1;
                            state_q    <= ST_WRACK;
                        end
                    end
                    ST_RDBYTE: begin
                        if (scl_rise) begin
                            bit_q <= bit_q + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_q == LAST_BIT) begin
                                oe_q    <= 1'b0;
                                ptr_q   <= ptr_q + 1'b1;
                                bit_q   <= '0;
                                state_q <= ST_RDACK;
                            end else begin
                                shift_q <= {shift_q[DW-2:0], 1'b0};
                                oe_q    <= ~shift_q[DW-2];
                            end
                        end
                    end
                    ST_RDACK: begin
                        if (scl_rise) begin
                            host_ack_q <= ~sda_lvl;
                        end else if (scl_fall) begin
                            bit_q <= '0;
                            if (host_ack_q) begin
                                shift_q <= rd_data;
                                oe_q    <= ~rd_data[DW-1];
                                state_q <= ST_RDBYTE;
                            end else begin
                                state_q <= ST_SKIP;
                            end
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign ptr     = ptr_q;
    assign sda_oe  = oe_q;
    assign wr_req  = req_q;
    assign wr_addr = req_addr_q;
    assign wr_data = req_data_q;
    assign state   = state_q;
endmodule

// File: rtl/twi_reg_bank.sv
// Byte register bank with one write port and two read ports. Port A is
// addressed by the full pointer width and returns zero above the bank.
// Port B is the parallel port. Writes above the bank are dropped and
// produce no accept pulse. Assumes NREGS is a power of two below 2**AW.
module twi_reg_bank #(
    parameter int NREGS = 16,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_req,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic                     wr_accept,
    input  logic [AW-1:0]            rd_addr_a,
    output logic [DW-1:0]            rd_data_a,
    input  logic [$clog2(NREGS)-1:0] rd_addr_b,
    output logic [DW-1:0]            rd_data_b
);
    localparam int IDX_W = $clog2(NREGS);
    localparam logic [AW:0] LIMIT = (AW + 1)'(NREGS);

    logic [DW-1:0] mem_q [NREGS];
    logic          wr_in_range;
    logic          rd_in_range;

    // Range checks against the implemented depth
    always_comb begin
        wr_in_range = {1'b0, wr_addr} < LIMIT;
        rd_in_range = {1'b0, rd_addr_a} < LIMIT;
        wr_accept   = wr_req & wr_in_range;
    end

    // Store accepted writes, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_accept) begin
            mem_q[wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    // Read ports, zero fill above the bank on port A
    always_comb begin
        rd_data_a = rd_in_range ? mem_q[rd_addr_a[IDX_W-1:0]] : '0;
        rd_data_b = mem_q[rd_addr_b];
    end
endmodule

// File: rtl/twi_reg_slave.sv
// Top of the two-wire register slave: line filters for SCL and SDA, bus
// event decoder, protocol controller and register bank. SDA leaves as an
// open-drain enable. Assumes the pad returns the wired-AND bus level on
// sda_i and that SCL is never held low by this block.
module twi_reg_slave
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ID      = 7'h33,
    parameter int         NREGS       = 16,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_TAPS   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe,
    input  logic [$clog2(NREGS)-1:0] par_addr,
    output logic [7:0]               par_rdata,
    output logic                     wr_stb,
    output logic [7:0]               wr_addr,
    output logic [7:0]               wr_data
);
    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw;
    logic [NLINES-1:0] line_flt;
    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [AW-1:0]     ptr;
    logic [DW-1:0]     rd_data;
    logic              wr_req;
    twi_state_e        fsm_state;

    assign line_raw = {sda_i, scl_i};

    // One synchronizer and majority filter per bus line
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        twi_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .TAPS       (FILT_TAPS)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(line_raw[g]),
            .line_o(line_flt[g])
        );
    end

    assign scl_lvl = line_flt[0];
    assign sda_lvl = line_flt[1];

    twi_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    twi_slave_fsm #(
        .DEV_ID(DEV_ID),
        .AW    (AW),
        .DW    (DW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_lvl  (sda_lvl),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .sda_oe   (sda_oe),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .state    (fsm_state)
    );

    twi_reg_bank #(
        .NREGS(NREGS),
        .AW   (AW),
        .DW   (DW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_accept(wr_stb),
        .rd_addr_a(ptr),
        .rd_data_a(rd_data),
        .rd_addr_b(par_addr),
        .rd_data_b(par_rdata)
    );
endmodule

// File: rtl/twi_reg_slave_chk.sv
// Property checker for the two-wire register slave, attached by bind.
// Observes the filtered SCL level, the SDA enable, the write strobe and
// the controller state. Assumes a well-formed host on the bus.
module twi_reg_slave_chk
    import twi_pkg::*;
#(
    parameter int NREGS = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [7:0] wr_addr,
    input twi_state_e state
);
    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    // R3
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R4
    stb_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (int'(wr_addr) < NREGS));

    // R2
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
endmodule

bind twi_reg_slave twi_reg_slave_chk #(.NREGS(NREGS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_lvl(scl_lvl),
    .sda_oe (sda_oe),
    .wr_stb (wr_stb),
    .wr_addr(wr_addr),
    .state  (fsm_state)
);

// File: tb/twi_reg_slave_bench.sv
// Bench: a bus master model drives SCL and SDA, and a register model
// supplies every expected value.
module twi_reg_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int NREGS      = 16;
    localparam logic [6:0] DEV = 7'h33;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       m_scl;
    logic       m_low;
    logic       glitch;
    logic       scl_bus;
    logic       sda_bus;
    logic       sda_oe;
    logic [3:0] par_addr;
    logic [7:0] par_rdata;
    logic       wr_stb;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;

    int n_checks = 0;
    int n_err    = 0;
    int stb_cnt  = 0;
    int oe_viol  = 0;
    logic [7:0] last_wa;
    logic [7:0] last_wd;
    logic       prev_oe = 1'b0;
    logic [7:0] exp_reg [NREGS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign scl_bus = m_scl | glitch;
    assign sda_bus = ~(m_low | sda_oe);

    twi_reg_slave u_twi_reg_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_bus),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .par_addr (par_addr),
        .par_rdata(par_rdata),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // Log write strobes and SDA enable changes while SCL is high
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            stb_cnt = stb_cnt + 1;
            last_wa = wr_addr;
            last_wd = wr_data;
        end
        if (rst_n && (sda_oe !== prev_oe) && scl_bus) oe_viol = oe_viol + 1;
        prev_oe = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic send_bit(input logic b, input logic glt);
        m_low = ~b;
        if (glt) begin
            tick(Q / 2); glitch = 1'b1; tick(1); glitch = 1'b0; tick(Q - Q / 2 - 1);
        end else begin
            tick(Q);
        end
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q / 2);
        b = sda_bus; tick(Q - Q / 2);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, input logic glt, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i], glt);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input logic more, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~more, 1'b0);
    endtask

    task automatic chk_reg(input string req, input int idx);
        par_addr = 4'(idx);
        tick(1);
        chk(req, par_rdata, exp_reg[idx]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        rst_n = 1'b0; m_scl = 1'b1; m_low = 1'b0; glitch = 1'b0; par_addr = '0;
        for (int i = 0; i < NREGS; i++) exp_reg[i] = 8'h00;
        tick(6);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state
        chk("R1 oe", sda_oe, 0);
        for (int i = 0; i < NREGS; i++) chk_reg("R1 reg", i);

        // R3: full write sweep from pointer 0
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack); chk("R3 dev ack", ack, 1);
        wr_byte(8'h00, 1'b0, ack);       chk("R3 ptr ack", ack, 1);
        for (int i = 0; i < NREGS; i++) begin
            exp_reg[i] = 8'((i * 37 + 11) ^ 8'h5A);
            wr_byte(exp_reg[i], 1'b0, ack);
            chk("R3 data ack", ack, 1);
        end
        bus_stop();
        chk("R3 strobes", stb_cnt, 16);
        chk("R3 last addr", last_wa, 15);
        chk("R3 last data", last_wd, exp_reg[15]);
        for (int i = 0; i < NREGS; i++) chk_reg("R3 reg", i);

        // R4: writes crossing the top of the bank
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'd14, 1'b0, ack);
        for (int i = 0; i < 4; i++) begin
            d = 8'hC0 + 8'(i);
            wr_byte(d, 1'b0, ack);
            chk("R4 ack", ack, 1);
            if (i < 2) exp_reg[14 + i] = d;
        end
        bus_stop();
        chk("R4 strobes", stb_cnt, 18);
        chk_reg("R4 reg14", 14);
        chk_reg("R4 reg15", 15);
        chk_reg("R4 reg0", 0);

        // R2: address sweep over all 7-bit codes
        for (int a = 0; a < 128; a++) begin
            bus_start();
            wr_byte({7'(a), 1'b0}, 1'b0, ack);
            chk("R2 addr ack", ack, (a == int'(DEV)) ? 1 : 0);
            bus_stop();
        end
        // R2: bytes after a mismatch are ignored
        bus_start();
        wr_byte({7'h32, 1'b0}, 1'b0, ack); chk("R2 miss ack", ack, 0);
        wr_byte(8'h00, 1'b0, ack);         chk("R2 miss ptr", ack, 0);
        wr_byte(8'hEE, 1'b0, ack);         chk("R2 miss data", ack, 0);
        bus_stop();
        chk_reg("R2 reg0 kept", 0);
        chk("R2 no strobe", stb_cnt, 18);

        // R5/R6: combined write-pointer then read past the bank
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'h00, 1'b0, ack);
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack); chk("R5 rd addr ack", ack, 1);
        for (int i = 0; i < 18; i++) begin
            rd_byte(i != 17, d);
            if (i < NREGS) chk("R5 read", d, exp_reg[i]);
            else           chk("R6 zero fill", d, 0);
        end
        // R9: released after not-acknowledge
        tick(2);
        chk("R9 oe after nack", sda_oe, 0);
        chk("R9 sda high", sda_bus, 1);
        bus_stop();
        chk("R9 oe after stop", sda_oe, 0);

        // R8: pointer survives STOP
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'd5, 1'b0, ack);
        bus_stop();
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack);
        rd_byte(1'b1, d); chk("R8 reg5", d, exp_reg[5]);
        rd_byte(1'b0, d); chk("R8 reg6", d, exp_reg[6]);
        bus_stop();

        // R7: pointer wrap on write and on read
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'hFF, 1'b0, ack);
        wr_byte(8'h5A, 1'b0, ack); chk("R7 ff ack", ack, 1);
        wr_byte(8'hC3, 1'b0, ack);
        bus_stop();
        exp_reg[0] = 8'hC3;
        chk_reg("R7 reg0", 0);
        chk("R7 strobes", stb_cnt, 19);
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'hFE, 1'b0, ack);
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack);
        rd_byte(1'b1, d); chk("R7 rd fe", d, 0);
        rd_byte(1'b1, d); chk("R7 rd ff", d, 0);
        rd_byte(1'b0, d); chk("R7 rd 00", d, 8'hC3);
        bus_stop();

        // R12: repeated START in write direction loads a new pointer
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'd3, 1'b0, ack);
        wr_byte(8'h11, 1'b0, ack);
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack); chk("R12 sr ack", ack, 1);
        wr_byte(8'd9, 1'b0, ack);
        wr_byte(8'h99, 1'b0, ack);
        bus_stop();
        exp_reg[3] = 8'h11;
        exp_reg[9] = 8'h99;
        chk_reg("R12 reg3", 3);
        chk_reg("R12 reg9", 9);

        // R11: single-cycle SCL glitches inside every bit
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'd7, 1'b0, ack);
        wr_byte(8'hA5, 1'b1, ack); chk("R11 ack", ack, 1);
        bus_stop();
        exp_reg[7] = 8'hA5;
        chk_reg("R11 reg7", 7);
        chk_reg("R11 reg8", 8);

        // R10: SDA enable never moved while SCL was high
        chk("R10 oe moves", oe_viol, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule